// File: doc/BRIEF.md
# Nibble ALU with Decimal Mode

This block is the arithmetic and logic stage of a small 4-bit processor, together with its four-bit flag register (interrupt enable I, decimal D, zero Z, carry C). Each cycle in which `op_valid` is high it takes two operands, a 5-bit operation code and an index-arithmetic qualifier, computes the result against the flags it currently holds, and on the next rising edge presents the registered result, a one-cycle write-enable for that result, and the updated flags.

Addition and subtraction are binary unless D is set, in which case the result is corrected to a decimal digit. The correction is suppressed for compare and whenever `idx_mode` marks the operation as arithmetic on an index-register nibble. Every operation touches only its own subset of flags. When an operation does not write, `res` keeps the last value written.

Top module: `nib_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `res` becomes 0, `res_we` 0 and all four flags 0.
- R2: With D clear or `idx_mode` high, code 0 (add) and code 1 (add plus C) write the low 4 bits of the sum, set C to the carry out and Z when the written value is 0.
- R3: With D clear or `idx_mode` high, code 2 (subtract) and code 3 (subtract minus C) write the low 4 bits of the difference, set C when a borrow occurs and Z when the written value is 0.
- R4: Code 4 (compare) does not write; it sets C when `opa` < `opb` and Z when they are equal, is never decimal-corrected, and leaves I and D unchanged.
- R5: Codes 5, 6, 7 (AND, OR, XOR) write the result and update Z only; code 8 (test AND) updates Z from `opa & opb` without writing; none of them changes C.
- R6: Code 9 writes the bitwise inverse of `opa` and updates Z only.
- R7: Code 10 writes `{C, opa[3:1]}`, loads C from `opa[0]` and leaves Z unchanged.
- R8: With D set and `idx_mode` low, an add whose binary sum (carry in included) exceeds 9 writes the sum plus 6 modulo 16 and sets C; otherwise it writes the sum and clears C.
- R9: With D set and `idx_mode` low, a subtract that borrows writes the binary difference minus 6 modulo 16 and sets C.
- R10: With `idx_mode` high, add and subtract give the binary result whatever D holds.
- R11: Codes 16/17 set/clear C, 18/19 set/clear Z, 20/21 set/clear D, 22/23 set/clear I; each changes only its own flag and does not write.
- R12: With `op_valid` low, or with an unassigned code (11 to 15, 24 to 31), `res` and all flags hold and `res_we` is 0.
- R13: Result and flags appear at the edge after the operation is accepted, and an operation issued in the very next cycle already uses the flags just produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation accepted this cycle |
| op_code | input | 5 | Operation code |
| opa | input | DATA_W | First operand |
| opb | input | DATA_W | Second operand |
| idx_mode | input | 1 | Index-register arithmetic, suppresses decimal correction |
| res | output | DATA_W | Registered result, holds the last value written |
| res_we | output | 1 | One-cycle strobe: `res` carries a new value |
| flg_i | output | 1 | Interrupt enable flag |
| flg_d | output | 1 | Decimal flag |
| flg_z | output | 1 | Zero flag |
| flg_c | output | 1 | Carry / borrow flag |

## Verification
The two functions that meet in one cycle are the update of the flag register by one operation and its use as carry, borrow or decimal mode by the operation issued right behind it. The bench issues operations back to back with no idle cycle, so every add-with-carry, subtract-with-borrow and rotate consumes a C written at the previous edge, and a carry produced by decimal correction feeds the next add directly. A bench model that carries its own flag state forward judges each cycle, so a stale or early flag shows up as a result or flag mismatch at the following edge.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_TST  = 5'd8,
    OP_NOT  = 5'd9,
    OP_RRC  = 5'd10,
    OP_SETC = 5'd16,
    OP_CLRC = 5'd17,
    OP_SETZ = 5'd18,
    OP_CLRZ = 5'd19,
    OP_SETD = 5'd20,
    OP_CLRD = 5'd21,
    OP_SETI = 5'd22,
    OP_CLRI = 5'd23
  } op_e;

  typedef enum logic [2:0] {
    LG_AND = 3'd0,
    LG_OR  = 3'd1,
    LG_XOR = 3'd2,
    LG_NOT = 3'd3,
    LG_RRC = 3'd4
  } lsel_e;

  // flag vector order: [3]=I [2]=D [1]=Z [0]=C
  typedef struct packed {
    logic i;
    logic d;
    logic z;
    logic c;
  } flags_t;

  typedef struct packed {
    logic       arith;
    logic       sub;
    logic       use_cin;
    logic       dec_ok;
    lsel_e      lsel;
    logic       wr;
    logic       upd_c;
    logic       upd_z;
    logic [3:0] fset;
    logic [3:0] fclr;
  } ctl_t;

endpackage

// File: rtl/nib_decode.sv
module nib_decode
  import nib_alu_pkg::*;
(
  input  logic [4:0] op_code,
  output ctl_t       ctl
);

  always_comb begin
    ctl = '0;
    ctl.lsel = LG_AND;
    case (op_code)
      OP_ADD: begin ctl.arith = 1'b1; ctl.dec_ok = 1'b1; ctl.wr = 1'b1;
                    ctl.upd_c = 1'b1; ctl.upd_z = 1'b1; end
      OP_ADC: begin ctl.arith = 1'b1; ctl.dec_ok = 1'b1; ctl.use_cin = 1'b1;
                    ctl.wr = 1'b1; ctl.upd_c = 1'b1; ctl.upd_z = 1'b1; end
      OP_SUB: begin ctl.arith = 1'b1; ctl.sub = 1'b1; ctl.dec_ok = 1'b1;
                    ctl.wr = 1'b1; ctl.upd_c = 1'b1; ctl.upd_z = 1'b1; end
      OP_SBC: begin ctl.arith = 1'b1; ctl.sub = 1'b1; ctl.dec_ok = 1'b1;
                    ctl.use_cin = 1'b1; ctl.wr = 1'b1; ctl.upd_c = 1'b1;
                    ctl.upd_z = 1'b1; end
      OP_CMP: begin ctl.arith = 1'b1; ctl.sub = 1'b1; ctl.upd_c = 1'b1;
                    ctl.upd_z = 1'b1; end
      OP_AND: begin ctl.lsel = LG_AND; ctl.wr = 1'b1; ctl.upd_z = 1'b1; end
      OP_OR:  begin ctl.lsel = LG_OR;  ctl.wr = 1'b1; ctl.upd_z = 1'b1; end
      OP_XOR: begin ctl.lsel = LG_XOR; ctl.wr = 1'b1; ctl.upd_z = 1'b1; end
      OP_TST: begin ctl.lsel = LG_AND; ctl.upd_z = 1'b1; end
      OP_NOT: begin ctl.lsel = LG_NOT; ctl.wr = 1'b1; ctl.upd_z = 1'b1; end
      OP_RRC: begin ctl.lsel = LG_RRC; ctl.wr = 1'b1; ctl.upd_c = 1'b1; end
      OP_SETC: ctl.fset = 4'b0001;
      OP_CLRC: ctl.fclr = 4'b0001;
      OP_SETZ: ctl.fset = 4'b0010;
      OP_CLRZ: ctl.fclr = 4'b0010;
      OP_SETD: ctl.fset = 4'b0100;
      OP_CLRD: ctl.fclr = 4'b0100;
      OP_SETI: ctl.fset = 4'b1000;
      OP_CLRI: ctl.fclr = 4'b1000;
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/nib_addsub.sv
module nib_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  input  logic         dec_en,
  output logic [W-1:0] sum,
  output logic         cy
);

  localparam logic [W:0]   DEC_MAX = (W + 1)'(9);
  localparam logic [W-1:0] DEC_ADJ = W'(6);

  logic [W:0] raw;

  always_comb begin
    if (sub) raw = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    else     raw = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  end

  generate
    if (W == 4) begin : g_bcd
      always_comb begin
        sum = raw[W-1:0];
        cy  = raw[W];
        if (dec_en) begin
          if (!sub && (raw > DEC_MAX)) begin
            sum = raw[W-1:0] + DEC_ADJ;
            cy  = 1'b1;
          end else if (sub && raw[W]) begin
            sum = raw[W-1:0] - DEC_ADJ;
          end
        end
      end
    end else begin : g_bin
      logic unused_dec;
      assign unused_dec = dec_en;
      always_comb begin
        sum = raw[W-1:0];
        cy  = raw[W];
      end
    end
  endgenerate

endmodule

// File: rtl/nib_logic.sv
module nib_logic
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  lsel_e        sel,
  output logic [W-1:0] y,
  output logic         cout
);

  always_comb begin
    cout = cin;
    case (sel)
      LG_AND: y = a & b;
      LG_OR:  y = a | b;
      LG_XOR: y = a ^ b;
      LG_NOT: y = ~a;
      LG_RRC: begin
        y    = {cin, a[W-1:1]};
        cout = a[0];
      end
      default: y = a & b;
    endcase
  end

endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [4:0]        op_code,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              idx_mode,
  output logic [DATA_W-1:0] res,
  output logic              res_we,
  output logic              flg_i,
  output logic              flg_d,
  output logic              flg_z,
  output logic              flg_c
);

  ctl_t              ctl;
  flags_t            flags_q, flags_n;
  logic [DATA_W-1:0] res_q, a_sum, l_y, alu_y;
  logic              we_q, a_cy, l_cy, alu_cy;

  nib_decode u_dec (
    .op_code (op_code),
    .ctl     (ctl)
  );

  nib_addsub #(.W(DATA_W)) u_arith (
    .a      (opa),
    .b      (opb),
    .cin    (ctl.use_cin & flags_q.c),
    .sub    (ctl.sub),
    .dec_en (ctl.dec_ok & flags_q.d & ~idx_mode),
    .sum    (a_sum),
    .cy     (a_cy)
  );

  nib_logic #(.W(DATA_W)) u_logic (
    .a    (opa),
    .b    (opb),
    .cin  (flags_q.c),
    .sel  (ctl.lsel),
    .y    (l_y),
    .cout (l_cy)
  );

  always_comb begin
    alu_y   = ctl.arith ? a_sum : l_y;
    alu_cy  = ctl.arith ? a_cy  : l_cy;
    flags_n = flags_q;
    if (ctl.upd_c) flags_n.c = alu_cy;
    if (ctl.upd_z) flags_n.z = (alu_y == '0);
    flags_n = (flags_n & ~ctl.fclr) | ctl.fset;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      we_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      we_q <= op_valid & ctl.wr;
      if (op_valid) begin
        flags_q <= flags_n;
        if (ctl.wr) res_q <= alu_y;
      end
    end
  end

  assign res    = res_q;
  assign res_we = we_q;
  assign flg_i  = flags_q.i;
  assign flg_d  = flags_q.d;
  assign flg_z  = flags_q.z;
  assign flg_c  = flags_q.c;

endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [4:0]   op_code,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         idx_mode,
  input logic [W-1:0] res,
  input logic         res_we,
  input logic         flg_i,
  input logic         flg_d,
  input logic         flg_z,
  input logic         flg_c
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (res == '0 && !res_we && !flg_i && !flg_d && !flg_z && !flg_c));

  p_idx_binary_r10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ADD && idx_mode) |=>
      (res_we && res == W'($past(opa) + $past(opb))));

  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CMP) |=>
      (!res_we && $stable(res) && flg_c == ($past(opa) < $past(opb))
       && flg_z == ($past(opa) == $past(opb))));

  p_logic_keep_c_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_AND || op_code == OP_OR ||
                  op_code == OP_XOR || op_code == OP_TST)) |=> $stable(flg_c));

  p_rrc_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_RRC) |=>
      (res[W-1] == $past(flg_c) && flg_c == $past(opa[0]) && $stable(flg_z)));

  p_set_i_r11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SETI) |=> (flg_i && !res_we && $stable(flg_d)));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!res_we && $stable(res) && $stable(flg_i) && $stable(flg_d)
                   && $stable(flg_z) && $stable(flg_c)));

endmodule

bind nib_alu nib_alu_chk #(.W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_code  (op_code),
  .opa      (opa),
  .opb      (opb),
  .idx_mode (idx_mode),
  .res      (res),
  .res_we   (res_we),
  .flg_i    (flg_i),
  .flg_d    (flg_d),
  .flg_z    (flg_z),
  .flg_c    (flg_c)
);

// File: tb/tb_nib_alu.sv
module tb_nib_alu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = 5'd0;
  logic [3:0] opa = 4'd0;
  logic [3:0] opb = 4'd0;
  logic       idx_mode = 1'b0;
  logic [3:0] res;
  logic       res_we, flg_i, flg_d, flg_z, flg_c;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [3:0] m_res = 4'd0;
  logic       m_we = 1'b0;
  logic       m_i = 1'b0, m_d = 1'b0, m_z = 1'b0, m_c = 1'b0;

  always #2 clk = ~clk;

  nib_alu #(.DATA_W(4)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opa(opa), .opb(opb), .idx_mode(idx_mode), .res(res), .res_we(res_we),
    .flg_i(flg_i), .flg_d(flg_d), .flg_z(flg_z), .flg_c(flg_c)
  );

  task automatic check(input string tag);
    checks++;
    if ({res, res_we, flg_i, flg_d, flg_z, flg_c} !==
        {m_res, m_we, m_i, m_d, m_z, m_c}) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h idx=%b: got res=%h we=%b IDZC=%b%b%b%b exp res=%h we=%b IDZC=%b%b%b%b",
               tag, op_code, opa, opb, idx_mode, res, res_we, flg_i, flg_d, flg_z, flg_c,
               m_res, m_we, m_i, m_d, m_z, m_c);
    end
  endtask

  // expected behaviour, computed from the requirements
  task automatic model(input int op, input int a, input int b, input bit ix);
    int s, r;
    bit wr;
    wr = 1'b0;
    r  = int'(m_res);
    case (op)
      0, 1: begin
        s = a + b + ((op == 1) ? int'(m_c) : 0);
        if (m_d && !ix && s > 9) begin r = (s + 6) % 16; m_c = 1'b1; end
        else begin r = s % 16; m_c = (s > 15); end
        m_z = (r == 0); wr = 1'b1;
      end
      2, 3: begin
        s = a - b - ((op == 3) ? int'(m_c) : 0);
        r = (s + 32) % 16;
        if (m_d && !ix && s < 0) r = (r + 10) % 16;
        m_c = (s < 0); m_z = (r == 0); wr = 1'b1;
      end
      4: begin m_c = (a < b); m_z = (a == b); end
      5: begin r = a & b; m_z = (r == 0); wr = 1'b1; end
      6: begin r = a | b; m_z = (r == 0); wr = 1'b1; end
      7: begin r = a ^ b; m_z = (r == 0); wr = 1'b1; end
      8: m_z = ((a & b) == 0);
      9: begin r = 15 - a; m_z = (r == 0); wr = 1'b1; end
      10: begin r = int'(m_c) * 8 + a / 2; m_c = a[0]; wr = 1'b1; end
      16: m_c = 1'b1;
      17: m_c = 1'b0;
      18: m_z = 1'b1;
      19: m_z = 1'b0;
      20: m_d = 1'b1;
      21: m_d = 1'b0;
      22: m_i = 1'b1;
      23: m_i = 1'b0;
      default: ;
    endcase
    m_res = 4'(r);
    m_we  = wr;
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic do_op(input int op, input int a, input int b, input bit ix,
                       input string tag);
    op_valid = 1'b1;
    op_code  = 5'(op);
    opa      = 4'(a);
    opb      = 4'(b);
    idx_mode = ix;
    model(op, a, b, ix);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input int op, input int a, input int b);
    op_valid = 1'b0;
    op_code  = 5'(op);
    opa      = 4'(a);
    opb      = 4'(b);
    m_we     = 1'b0;
    @(negedge clk);
    check("R12");
  endtask

  function automatic string arith_tag(input int op, input bit ix);
    if (op == 4) return "R4";
    if (ix) return "R10";
    if (m_d) return (op < 2) ? "R8" : "R9";
    return (op < 2) ? "R2" : "R3";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1");

    // arithmetic sweep: every operand pair, both carry states, D and idx
    for (int op = 0; op <= 4; op++)
      for (int dm = 0; dm < 2; dm++)
        for (int ix = 0; ix < 2; ix++) begin
          do_op(dm ? 20 : 21, 0, 0, 1'b0, "R11");
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
              for (int cf = 0; cf < 2; cf++) begin
                do_op(cf ? 16 : 17, a, b, 1'b0, "R11");
                do_op(op, a, b, ix[0], arith_tag(op, ix[0]));
              end
        end

    // logic and rotate sweep with both carry states (R5, R6, R7)
    for (int op = 5; op <= 10; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int cf = 0; cf < 2; cf++) begin
            do_op(cf ? 16 : 17, a, b, 1'b0, "R11");
            do_op(op, a, b, 1'b0, (op == 10) ? "R7" : (op == 9) ? "R6" : "R5");
          end

    // each flag set and cleared on its own
    for (int k = 16; k <= 23; k++) do_op(k, 5, 3, 1'b0, "R11");
    for (int k = 23; k >= 16; k--) do_op(k, 0, 0, 1'b0, "R11");

    // R13: decimal carry feeds the next add in the following cycle
    do_op(20, 0, 0, 1'b0, "R11");
    do_op(17, 0, 0, 1'b0, "R11");
    do_op(1, 9, 9, 1'b0, "R13");
    do_op(1, 0, 0, 1'b0, "R13");
    do_op(3, 2, 5, 1'b0, "R13");
    do_op(3, 4, 0, 1'b0, "R13");

    // R12: idle cycles and unassigned codes change nothing
    do_op(0, 7, 5, 1'b0, "R13");
    do_op(22, 0, 0, 1'b0, "R11");
    idle(0, 9, 9);
    idle(20, 1, 1);
    for (int k = 11; k <= 15; k++) do_op(k, 15, 15, 1'b0, "R12");
    for (int k = 24; k <= 31; k++) do_op(k, 15, 15, 1'b0, "R12");
    idle(10, 1, 0);

    // R1: reset in mid-run clears everything
    do_op(16, 0, 0, 1'b0, "R11");
    rst = 1'b1;
    op_valid = 1'b0;
    @(negedge clk);
    m_res = 4'd0; m_we = 1'b0; m_i = 1'b0; m_d = 1'b0; m_z = 1'b0; m_c = 1'b0;
    check("R1");
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule